// File: doc/BRIEF.md
# Serial ADC host controller

This block is the host side of a synchronous serial link to a multiplexed analog-to-digital converter. One request from the system side starts a full exchange. The block first sends a 5-bit control word to the converter. The word selects the input channel, the power-down state and whether a conversion should start. If a conversion was started, the block waits a programmable number of cycles while the converter works. It then reads back 15 bits: a 3-bit channel tag followed by the 12-bit result.

The host generates both the serial clock and a framing signal, and the framing signal stays high for the whole of each frame. The serial clock comes from the system clock through a parameterised divider. It is gated, so it sits low whenever no frame is active, including the whole conversion wait. The system side sees only a request input, the control fields, a wait count, a busy level, a one-cycle done pulse and the captured result registers.

Top module: `sadc_host_ctrl`

## Requirements
- R1: After reset, adc_frame, adc_sclk, adc_mosi, busy and done are 0, and res_data and res_chan are 0.
- R2: A request accepted while idle produces a write frame of exactly 5 serial clock pulses. During it the word {ctl_chan[2], ctl_chan[1], ctl_chan[0], ctl_pwrdn, ctl_start} appears on adc_mosi in that order, one bit per pulse. adc_mosi never changes while adc_sclk is high.
- R3: adc_sclk idles low and toggles only while adc_frame is high. Each serial period is 2*HALF_DIV system cycles, and a frame of N bits keeps adc_frame high for exactly 2*HALF_DIV*N cycles.
- R4: The read frame has exactly 15 serial clock pulses, and adc_miso is sampled at each rising edge of adc_sclk. The first 3 bits sampled, MSB first, become res_chan. The next 12 bits, MSB first, become res_data.
- R5: Between the end of the write frame and the start of the read frame, adc_frame stays low for exactly conv_wait+2 cycles when ctl_start was 1. It stays low for exactly 2 cycles when ctl_start was 0, whatever conv_wait is. ctl_start and conv_wait are taken at request time.
- R6: done is a single-cycle pulse after the read frame. In the done cycle res_data and res_chan already hold the new result, and busy is 0.
- R7: A request made while busy is ignored. It starts no extra frame, and its control fields are not transmitted.
- R8: adc_mosi is 0 throughout the read frame.
- R9: While idle, res_data and res_chan hold their values, and adc_sclk and adc_frame stay low even if the control inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start an exchange (taken only while idle) |
| ctl_chan | input | 3 | Channel to select in the converter |
| ctl_pwrdn | input | 1 | Power-down bit of the control word |
| ctl_start | input | 1 | Start-conversion bit of the control word |
| conv_wait | input | WAIT_W | Conversion wait length in system cycles |
| busy | output | 1 | High from request acceptance until the read frame ends |
| done | output | 1 | One-cycle pulse when a result has been captured |
| res_data | output | 12 | Captured conversion result |
| res_chan | output | 3 | Captured channel tag |
| adc_sclk | output | 1 | Gated serial clock to the converter |
| adc_frame | output | 1 | Framing signal, high for a whole frame |
| adc_mosi | output | 1 | Serial data to the converter |
| adc_miso | input | 1 | Serial data from the converter |

## Verification
The hardest situation to reach from the ports is a request arriving while busy. For it to be tested, the rejected request must carry different control fields, and its start bit must differ from the accepted one. Only then would a wrongly accepted request show up in the transmitted word, in the frame count and in the converter's conversion count. The bench injects such requests at several offsets into the exchange, covering the write frame, the conversion wait and the read frame. Directed cases cover a zero wait, the largest wait, and a large wait with the start bit clear, which must collapse the gap to two cycles. Random exchanges vary channel, power-down, start and wait length.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CHAN_W  = 3;
    localparam int DATA_W  = 12;
    localparam int CTRL_W  = CHAN_W + 2;
    localparam int FRAME_W = CHAN_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    // control word as it goes on the wire, MSB first
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              pwrdn;
        logic              start;
    } ctrl_word_t;

    // read frame as it arrives, tag first
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } sample_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_READ
    } host_state_t;

    function automatic logic [FRAME_W-1:0] ctrl_to_frame(ctrl_word_t c);
        return {c, {(FRAME_W - CTRL_W){1'b0}}};
    endfunction

    function automatic sample_t frame_to_sample(logic [FRAME_W-1:0] w);
        return sample_t'(w);
    endfunction

endpackage

// File: rtl/sadc_serial_eng.sv
module sadc_serial_eng #(
    parameter int HALF_DIV = 2,
    parameter int FRAME_W  = 15,
    parameter int LEN_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic [LEN_W-1:0]   len,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               frame,
    output logic               sclk,
    output logic               mosi,
    output logic               fin,
    output logic [FRAME_W-1:0] rx_word
);

    localparam int              HC_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

    logic [HC_W-1:0]    half_cnt;
    logic [LEN_W-1:0]   bit_cnt;
    logic [LEN_W-1:0]   len_q;
    logic [FRAME_W-1:0] tx_sr;
    logic               active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            sclk     <= 1'b0;
            fin      <= 1'b0;
            half_cnt <= '0;
            bit_cnt  <= '0;
            len_q    <= '0;
            tx_sr    <= '0;
            rx_word  <= '0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    sclk     <= 1'b0;
                    half_cnt <= '0;
                    bit_cnt  <= '0;
                    len_q    <= len;
                    tx_sr    <= tx_word;
                end
            end else if (half_cnt != HC_LAST) begin
                half_cnt <= half_cnt + HC_W'(1);
            end else begin
                half_cnt <= '0;
                if (!sclk) begin
                    // rising edge: sample the converter
                    sclk    <= 1'b1;
                    rx_word <= {rx_word[FRAME_W-2:0], miso};
                end else begin
                    // falling edge: advance or close the frame
                    sclk <= 1'b0;
                    if (bit_cnt == len_q - LEN_W'(1)) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                        tx_sr  <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + LEN_W'(1);
                        tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign frame = active;
    assign mosi  = tx_sr[FRAME_W-1];

endmodule

// File: rtl/sadc_wait_timer.sv
module sadc_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sadc_host_ctrl.sv
module sadc_host_ctrl
    import sadc_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int WAIT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [CHAN_W-1:0] ctl_chan,
    input  logic              ctl_pwrdn,
    input  logic              ctl_start,
    input  logic [WAIT_W-1:0] conv_wait,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic              adc_sclk,
    output logic              adc_frame,
    output logic              adc_mosi,
    input  logic              adc_miso
);

    host_state_t        state;
    logic               start_q;
    logic [WAIT_W-1:0]  wait_q;
    sample_t            res_q;

    logic               go_wr;
    logic               go_rd;
    logic               eng_go;
    logic [LEN_W-1:0]   eng_len;
    logic [FRAME_W-1:0] eng_tx;
    logic               eng_fin;
    logic [FRAME_W-1:0] eng_rx;
    logic               tmr_load;
    logic [WAIT_W-1:0]  tmr_val;
    logic               tmr_zero;
    ctrl_word_t         ctl_now;

    assign ctl_now  = '{chan: ctl_chan, pwrdn: ctl_pwrdn, start: ctl_start};
    assign go_wr    = (state == ST_IDLE) && req;
    assign go_rd    = (state == ST_WAIT) && tmr_zero;
    assign eng_go   = go_wr || go_rd;
    assign eng_len  = go_wr ? LEN_W'(CTRL_W) : LEN_W'(FRAME_W);
    assign eng_tx   = go_wr ? ctrl_to_frame(ctl_now) : '0;
    assign tmr_load = (state == ST_WRITE) && eng_fin;
    assign tmr_val  = start_q ? wait_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
            wait_q  <= '0;
            res_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req) begin
                        start_q <= ctl_start;
                        wait_q  <= conv_wait;
                        state   <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (eng_fin) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (tmr_zero) state <= ST_READ;
                end
                ST_READ: begin
                    if (eng_fin) begin
                        res_q <= frame_to_sample(eng_rx);
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sadc_serial_eng #(
        .HALF_DIV (HALF_DIV),
        .FRAME_W  (FRAME_W),
        .LEN_W    (LEN_W)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .go      (eng_go),
        .len     (eng_len),
        .tx_word (eng_tx),
        .miso    (adc_miso),
        .frame   (adc_frame),
        .sclk    (adc_sclk),
        .mosi    (adc_mosi),
        .fin     (eng_fin),
        .rx_word (eng_rx)
    );

    sadc_wait_timer #(
        .W (WAIT_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign busy     = (state != ST_IDLE);
    assign res_data = res_q.data;
    assign res_chan = res_q.chan;

endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] res_data,
    input logic [CHAN_W-1:0] res_chan,
    input logic              adc_sclk,
    input logic              adc_frame,
    input logic              adc_mosi
);

    // R3: serial clock is gated off outside a frame
    assert_sclk_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !adc_frame |-> !adc_sclk);

    // R2: frames only occur inside an accepted exchange
    assert_frame_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        adc_frame |-> busy);

    // R2: data toward the converter is steady while the clock is high
    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> $stable(adc_mosi));

    // R6: done lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: done arrives with the block idle and the frame closed
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !adc_frame));

    // R7: an exchange ends only through done
    assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9: result registers move only on done
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_data) && $stable(res_chan)));

endmodule

bind sadc_host_ctrl sadc_host_chk #(
    .DATA_W (sadc_pkg::DATA_W),
    .CHAN_W (sadc_pkg::CHAN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .res_data  (res_data),
    .res_chan  (res_chan),
    .adc_sclk  (adc_sclk),
    .adc_frame (adc_frame),
    .adc_mosi  (adc_mosi)
);

// File: tb/sadc_host_ctrl_test.sv
module sadc_host_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int WAIT_W     = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [2:0]        ctl_chan = '0;
    logic              ctl_pwrdn = 1'b0;
    logic              ctl_start = 1'b0;
    logic [WAIT_W-1:0] conv_wait = '0;
    logic              busy, done, adc_sclk, adc_frame, adc_mosi;
    logic              adc_miso = 1'b0;
    logic [11:0]       res_data;
    logic [2:0]        res_chan;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sadc_host_ctrl #(.HALF_DIV(HALF_DIV), .WAIT_W(WAIT_W)) uut (
        .clk(clk), .rst(rst), .req(req), .ctl_chan(ctl_chan),
        .ctl_pwrdn(ctl_pwrdn), .ctl_start(ctl_start), .conv_wait(conv_wait),
        .busy(busy), .done(done), .res_data(res_data), .res_chan(res_chan),
        .adc_sclk(adc_sclk), .adc_frame(adc_frame), .adc_mosi(adc_mosi),
        .adc_miso(adc_miso)
    );

    function automatic logic [11:0] conv_val(input logic [2:0] ch, input int n);
        return 12'((int'(ch) * 421 + n * 1117 + 5) % 4096);
    endfunction

    // ---------------- behavioural converter stand-in ----------------
    int          frame_no = 0;
    logic [4:0]  ctl_sr = '0;
    logic [4:0]  last_ctl = '0;
    int          wbits = 0, rbits = 0, last_wbits = 0, last_rbits = 0;
    logic [14:0] out_sr = '0;
    logic [2:0]  m_chan = '0;
    int          m_conv = 0;
    int          mosi_rd_hi = 0;
    int          sclk_rises = 0;

    always @(posedge adc_frame) if (!rst) begin
        if (frame_no % 2 == 0) begin
            wbits  = 0;
            ctl_sr = '0;
        end else begin
            rbits    = 0;
            out_sr   = {m_chan, conv_val(m_chan, m_conv)};
            adc_miso = out_sr[14];
        end
    end

    always @(posedge adc_sclk) if (!rst) begin
        sclk_rises++;
        if (frame_no % 2 == 0) begin
            ctl_sr = {ctl_sr[3:0], adc_mosi};
            wbits++;
        end else begin
            rbits++;
            if (adc_mosi) mosi_rd_hi++;
        end
    end

    always @(negedge adc_sclk) if (!rst) begin
        if (frame_no % 2 == 1) begin
            out_sr   = {out_sr[13:0], 1'b0};
            adc_miso = out_sr[14];
        end
    end

    always @(negedge adc_frame) if (!rst) begin
        if (frame_no % 2 == 0) begin
            last_ctl   = ctl_sr;
            last_wbits = wbits;
            m_chan     = ctl_sr[4:2];
            if (ctl_sr[0]) m_conv++;
        end else begin
            last_rbits = rbits;
            adc_miso   = 1'b0;
        end
        frame_no++;
    end

    // ---------------- frame timing monitor ----------------
    logic prev_fr = 1'b0;
    int   hi_run = 0, lo_run = 0, wr_len = 0, rd_len = 0, rd_gap = 0;

    always @(negedge clk) begin
        if (rst) begin
            prev_fr = 1'b0; hi_run = 0; lo_run = 0;
        end else begin
            if (adc_frame) begin
                if (!prev_fr) begin
                    if (frame_no % 2 == 1) rd_gap = lo_run;
                    lo_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_fr) begin
                    if (frame_no % 2 == 1) wr_len = hi_run;
                    else rd_len = hi_run;
                    hi_run = 0;
                end
                lo_run++;
            end
            prev_fr = adc_frame;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    int exp_conv = 0;
    int exp_frames = 0;

    task automatic xfer(input logic [2:0] ch, input logic pd, input logic st,
                        input int w, input int inject_at);
        int n;
        @(negedge clk);
        ctl_chan = ch; ctl_pwrdn = pd; ctl_start = st; conv_wait = WAIT_W'(w);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (inject_at > 0) begin
            repeat (inject_at) @(negedge clk);
            ctl_chan = ~ch; ctl_pwrdn = ~pd; ctl_start = ~st;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (st) exp_conv++;
        exp_frames += 2;
        check("R6 done seen", int'(done), 1);
        check("R6 busy low at done", int'(busy), 0);
        check("R4 res_chan", int'(res_chan), int'(ch));
        check("R4 res_data", int'(res_data), int'(conv_val(ch, exp_conv)));
        check("R2 control word", int'(last_ctl), int'({ch, pd, st}));
        check("R2 write pulses", last_wbits, 5);
        check("R4 read pulses", last_rbits, 15);
        check("R3 write frame length", wr_len, 2 * HALF_DIV * 5);
        check("R3 read frame length", rd_len, 2 * HALF_DIV * 15);
        check("R5 gap", rd_gap, st ? w + 2 : 2);
        check("R8 mosi high in read", mosi_rd_hi, 0);
        check("R7 frame count", frame_no, exp_frames);
        @(negedge clk);
        check("R6 done single cycle", int'(done), 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [11:0] hold_d;
        logic [2:0]  hold_c;
        int          rises0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 frame", int'(adc_frame), 0);
        check("R1 sclk", int'(adc_sclk), 0);
        check("R1 mosi", int'(adc_mosi), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 res_data", int'(res_data), 0);
        check("R1 res_chan", int'(res_chan), 0);

        // directed corners
        xfer(3'd5, 1'b0, 1'b1, 0, 0);      // R5 zero wait
        xfer(3'd2, 1'b1, 1'b1, 255, 0);    // R5 largest wait
        xfer(3'd7, 1'b0, 1'b0, 200, 0);    // R5 wait ignored without start
        xfer(3'd1, 1'b0, 1'b1, 30, 5);     // R7 request during write frame
        xfer(3'd6, 1'b1, 1'b1, 60, 40);    // R7 request during wait
        xfer(3'd3, 1'b0, 1'b0, 10, 50);    // R7 request during read frame

        // R9: idle input changes leave everything still
        hold_d = res_data; hold_c = res_chan; rises0 = sclk_rises;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ctl_chan = 3'(i); ctl_start = i[0]; conv_wait = WAIT_W'(i);
            if (adc_frame) check("R9 frame idle", 1, 0);
        end
        check("R9 res_data hold", int'(res_data), int'(hold_d));
        check("R9 res_chan hold", int'(res_chan), int'(hold_c));
        check("R9 no sclk while idle", sclk_rises, rises0);

        // random exchanges
        for (int k = 0; k < 30; k++) begin
            xfer(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 40)),
                 (k % 4 == 0) ? int'($urandom_range(1, 70)) : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule